// File: doc/BRIEF.md
# Stress and Measurement Phase Sequencer

This block drives the three control lines of an aging-monitor ring oscillator: a stress-enable line, an AC-stress select and a toggle select. Most of the time the oscillator sits under stress in one of three styles, chosen through a configuration input: DC stress with the node held, DC stress with the node toggled, or AC stress. Now and then the sequencer drops the stress-enable line, which places the oscillator in measurement mode. It raises a beat-counter enable for a short window and then returns straight to stress. The window is kept short so the stressed devices have almost no time to recover.

A window opens when the stress interval, a programmable cycle count, runs out, or at once when a request input is pulsed. It closes as soon as the beat counter signals a valid result, or when the configured window length is reached, whichever comes first. A build-time cap holds every window below the platform's sub-microsecond budget. As each window closes the block emits a one-cycle done pulse and advances a wrapping window counter. A stress style chosen while a window is open is applied when stress resumes.

Top module: `stress_meas_seq`

## Requirements
- R1: While reset is low: osc_stress=1, osc_ac=0, osc_tgl=0, cnt_en=0, win_done=0 and win_count=0.
- R2: In a stress cycle the line triple {osc_stress,osc_ac,osc_tgl} follows cfg_mode from the previous cycle: 2'b00 gives 3'b100, 2'b01 gives 3'b101, 2'b10 gives 3'b110 and 2'b11 gives 3'b100.
- R3: In every measurement cycle cnt_en=1 and {osc_stress,osc_ac,osc_tgl}=3'b000. In every stress cycle cnt_en=0 and osc_stress=1.
- R4: With no request, a stress interval lasts exactly max(cfg_stress_len,1) cycles before cnt_en rises.
- R5: A meas_req sampled high during stress makes the next cycle a measurement cycle. meas_req has no effect during a measurement window.
- R6: With no valid result, a window lasts exactly min(max(cfg_meas_len,1), MEAS_CAP) cycles.
- R7: A result_valid sampled high during a window makes the next cycle a stress cycle. result_valid has no effect during stress.
- R8: win_done is high for exactly the first stress cycle after each window. In that same cycle win_count shows its previous value plus one, modulo 2^CNT_W. It holds its value at all other times.
- R9: A cfg_mode change made during a window leaves the lines at 3'b000 until the window ends. The first stress cycle after the window shows the new mode's encoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Stress style select (see R2) |
| cfg_stress_len | input | SLEN_W | Stress interval length in cycles |
| cfg_meas_len | input | MLEN_W | Measurement window limit in cycles |
| meas_req | input | 1 | Opens a window at the next cycle |
| result_valid | input | 1 | Beat counter has a result; closes the window |
| osc_stress | output | 1 | Stress enable; low means measurement mode |
| osc_ac | output | 1 | AC-stress select |
| osc_tgl | output | 1 | Toggle select for DC stress |
| cnt_en | output | 1 | Beat counter enable, high for the whole window |
| win_done | output | 1 | One-cycle pulse as a window closes |
| win_count | output | CNT_W | Completed window count, wraps |

## Verification
All outputs come from registers, so every response lands one clock after the input that causes it. That holds for a request opening a window, for a valid result closing it, for the done pulse together with the count step, and for a mode change appearing on the lines. The bench drives inputs on the falling edge and samples the outputs on the following falling edges, so each expectation is read half a period after the rising edge that should produce it. Interval and window lengths are measured by counting consecutive sampled cycles of each phase. These counts are compared against max(L,1) and min(max(M,1),cap) over a full sweep of small lengths. The window counter is followed by an independent modulo counter that advances on every sampled done pulse.

// File: rtl/smseq_pkg.sv
`timescale 1ns/1ps
package smseq_pkg;

    typedef enum logic [1:0] {
        MODE_DC_HOLD = 2'b00,
        MODE_DC_TGL  = 2'b01,
        MODE_AC      = 2'b10,
        MODE_RSVD    = 2'b11
    } stress_mode_e;

    typedef enum logic {
        PH_STRESS = 1'b0,
        PH_MEAS   = 1'b1
    } phase_e;

    typedef struct packed {
        logic stress;
        logic ac;
        logic tgl;
    } osc_ctl_t;

endpackage

// File: rtl/smseq_span_timer.sv
`timescale 1ns/1ps
// Counts consecutive active cycles; flags the cycle that completes the span.
module smseq_span_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active,
    input  logic [W-1:0] limit,
    output logic         last
);
    logic [W-1:0] cnt_d, cnt_q;
    logic [W:0]   nxt;

    always_comb begin
        nxt   = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};
        last  = active && (nxt >= {1'b0, limit});
        cnt_d = cnt_q;
        if (!active) begin
            cnt_d = '0;
        end else if (!last) begin
            cnt_d = nxt[W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/smseq_lim_clamp.sv
`timescale 1ns/1ps
// Clamps the configured window length to the build-time cap.
module smseq_lim_clamp #(
    parameter int W   = 8,
    parameter int CAP = 100
) (
    input  logic [W-1:0] cfg,
    output logic [W-1:0] lim
);
    localparam logic [W-1:0] CAP_V = W'(CAP);

    always_comb begin
        lim = (cfg > CAP_V) ? CAP_V : cfg;
    end
endmodule

// File: rtl/smseq_ctl_enc.sv
`timescale 1ns/1ps
// Decodes phase and stress style into the oscillator control lines.
module smseq_ctl_enc
    import smseq_pkg::*;
(
    input  phase_e       phase,
    input  stress_mode_e mode,
    output osc_ctl_t     ctl,
    output logic         cnt_en
);
    always_comb begin
        cnt_en = (phase == PH_MEAS);
        ctl    = '{stress: 1'b0, ac: 1'b0, tgl: 1'b0};
        if (phase == PH_STRESS) begin
            unique case (mode)
                MODE_DC_TGL: ctl = '{stress: 1'b1, ac: 1'b0, tgl: 1'b1};
                MODE_AC:     ctl = '{stress: 1'b1, ac: 1'b1, tgl: 1'b0};
                default:     ctl = '{stress: 1'b1, ac: 1'b0, tgl: 1'b0};
            endcase
        end
    end
endmodule

// File: rtl/stress_meas_seq.sv
`timescale 1ns/1ps
module stress_meas_seq
    import smseq_pkg::*;
#(
    parameter int SLEN_W   = 16,
    parameter int MLEN_W   = 8,
    parameter int CNT_W    = 16,
    parameter int MEAS_CAP = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic [SLEN_W-1:0] cfg_stress_len,
    input  logic [MLEN_W-1:0] cfg_meas_len,
    input  logic              meas_req,
    input  logic              result_valid,
    output logic              osc_stress,
    output logic              osc_ac,
    output logic              osc_tgl,
    output logic              cnt_en,
    output logic              win_done,
    output logic [CNT_W-1:0]  win_count
);
    typedef struct packed {
        phase_e            phase;
        stress_mode_e      mode;
        logic              done;
        logic [CNT_W-1:0]  cnt;
    } seq_t;

    seq_t s_d, s_q;

    logic              stress_last;
    logic              meas_last;
    logic [MLEN_W-1:0] meas_lim;
    osc_ctl_t          ctl;

    smseq_lim_clamp #(.W(MLEN_W), .CAP(MEAS_CAP)) u_clamp (
        .cfg (cfg_meas_len),
        .lim (meas_lim)
    );

    smseq_span_timer #(.W(SLEN_W)) u_stress_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (s_q.phase == PH_STRESS),
        .limit  (cfg_stress_len),
        .last   (stress_last)
    );

    smseq_span_timer #(.W(MLEN_W)) u_meas_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (s_q.phase == PH_MEAS),
        .limit  (meas_lim),
        .last   (meas_last)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.phase)
            PH_STRESS: begin
                s_d.mode = stress_mode_e'(cfg_mode);
                if (meas_req || stress_last) begin
                    s_d.phase = PH_MEAS;
                end
            end
            PH_MEAS: begin
                if (result_valid || meas_last) begin
                    s_d.phase = PH_STRESS;
                    s_d.mode  = stress_mode_e'(cfg_mode);
                    s_d.done  = 1'b1;
                    s_d.cnt   = s_q.cnt + {{(CNT_W-1){1'b0}}, 1'b1};
                end
            end
            default: s_d.phase = PH_STRESS;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_STRESS, mode: MODE_DC_HOLD, done: 1'b0, cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    smseq_ctl_enc u_enc (
        .phase  (s_q.phase),
        .mode   (s_q.mode),
        .ctl    (ctl),
        .cnt_en (cnt_en)
    );

    assign osc_stress = ctl.stress;
    assign osc_ac     = ctl.ac;
    assign osc_tgl    = ctl.tgl;
    assign win_done   = s_q.done;
    assign win_count  = s_q.cnt;
endmodule

// File: rtl/stress_meas_seq_chk.sv
`timescale 1ns/1ps
module stress_meas_seq_chk #(
    parameter int CNT_W    = 16,
    parameter int MEAS_CAP = 100
) (
    input logic             clk,
    input logic             rst_n,
    input logic             meas_req,
    input logic             result_valid,
    input logic             osc_stress,
    input logic             osc_ac,
    input logic             osc_tgl,
    input logic             cnt_en,
    input logic             win_done,
    input logic [CNT_W-1:0] win_count
);
    logic [15:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (cnt_en) begin
            run_q <= run_q + 16'd1;
        end else begin
            run_q <= '0;
        end
    end

    p_meas_lines_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en |-> (!osc_stress && !osc_ac && !osc_tgl));

    p_stress_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |-> osc_stress);

    p_tgl_excl_ac_r2: assert property (@(posedge clk) disable iff (!rst_n)
        osc_tgl |-> !osc_ac);

    p_req_opens_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && meas_req) |=> cnt_en);

    p_valid_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && result_valid) |=> !cnt_en);

    p_window_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en |-> (run_q < 16'(MEAS_CAP)));

    p_done_after_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |-> ($past(cnt_en) && !cnt_en));

    p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |-> (win_count == $past(win_count) + CNT_W'(1)));

    p_count_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !win_done |-> $stable(win_count));
endmodule

bind stress_meas_seq stress_meas_seq_chk #(.CNT_W(CNT_W), .MEAS_CAP(MEAS_CAP)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .meas_req     (meas_req),
    .result_valid (result_valid),
    .osc_stress   (osc_stress),
    .osc_ac       (osc_ac),
    .osc_tgl      (osc_tgl),
    .cnt_en       (cnt_en),
    .win_done     (win_done),
    .win_count    (win_count)
);

// File: tb/sim_stress_meas_seq.sv
`timescale 1ns/1ps
module sim_stress_meas_seq;
    localparam int SLEN_W = 12;
    localparam int MLEN_W = 4;
    localparam int CNT_W  = 4;
    localparam int CAP    = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        cfg_mode = 2'b00;
    logic [SLEN_W-1:0] cfg_stress_len = 12'd1000;
    logic [MLEN_W-1:0] cfg_meas_len = 4'd3;
    logic              meas_req = 1'b0;
    logic              result_valid = 1'b0;
    logic              osc_stress, osc_ac, osc_tgl, cnt_en, win_done;
    logic [CNT_W-1:0]  win_count;

    int n_cmp = 0;
    int n_bad = 0;
    logic [CNT_W-1:0] exp_cnt = '0;

    always #2.5 clk = ~clk;

    stress_meas_seq #(.SLEN_W(SLEN_W), .MLEN_W(MLEN_W), .CNT_W(CNT_W), .MEAS_CAP(CAP)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_stress_len(cfg_stress_len),
        .cfg_meas_len(cfg_meas_len), .meas_req(meas_req), .result_valid(result_valid),
        .osc_stress(osc_stress), .osc_ac(osc_ac), .osc_tgl(osc_tgl), .cnt_en(cnt_en),
        .win_done(win_done), .win_count(win_count)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wait_done();
        tick();
        while (!win_done) tick();
    endtask

    function automatic logic [2:0] enc(input int m);
        if (m == 1) return 3'b101;
        if (m == 2) return 3'b110;
        return 3'b100;
    endfunction

    function automatic logic [2:0] lines();
        return {osc_stress, osc_ac, osc_tgl};
    endfunction

    // R8: independent window counter, advanced on each observed done pulse
    always @(negedge clk) begin
        if (rst_n && win_done) begin
            exp_cnt = exp_cnt + 1'b1;
            chk(win_count == exp_cnt, "R8 win_count step", win_count, exp_cnt);
        end
    end

    initial begin
        #1000000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        // R1 reset state
        chk(lines() == 3'b100, "R1 lines in reset", lines(), 3'b100);
        chk(cnt_en == 1'b0, "R1 cnt_en in reset", cnt_en, 0);
        chk(win_done == 1'b0, "R1 done in reset", win_done, 0);
        chk(win_count == '0, "R1 count in reset", win_count, 0);
        rst_n = 1'b1;
        tick();

        // R2 mode encodings during stress
        for (int m = 0; m < 4; m++) begin
            cfg_mode = 2'(m);
            tick();
            chk(lines() == enc(m), "R2 stress encoding", lines(), enc(m));
            chk(cnt_en == 1'b0, "R3 no window yet", cnt_en, 0);
        end

        // R4 / R6 / R3 / R8 sweep over interval and window lengths
        cfg_mode = 2'b01;
        for (int L = 0; L < 6; L++) begin
            for (int M = 0; M < 16; M++) begin
                int n;
                int w;
                int expl;
                int expw;
                cfg_stress_len = 12'(L);
                cfg_meas_len   = 4'(M);
                expl = (L < 1) ? 1 : L;
                expw = (M < 1) ? 1 : ((M > CAP) ? CAP : M);
                wait_done();
                n = 1;
                chk(lines() == 3'b101, "R3 stress lines", lines(), 3'b101);
                tick();
                while (!cnt_en && n < 100) begin
                    chk(win_done == 1'b0, "R8 done single cycle", win_done, 0);
                    n++;
                    tick();
                end
                chk(n == expl, "R4 stress interval", n, expl);
                chk(lines() == 3'b000, "R3 window lines", lines(), 0);
                w = 1;
                tick();
                while (cnt_en && w < 100) begin
                    chk(win_done == 1'b0, "R8 no done in window", win_done, 0);
                    w++;
                    tick();
                end
                chk(w == expw, "R6 window length", w, expw);
                chk(win_done == 1'b1, "R8 done after window", win_done, 1);
            end
        end

        // R5 request opens a window; ignored inside one
        cfg_stress_len = 12'd1000;
        cfg_meas_len   = 4'd3;
        wait_done();
        tick();
        tick();
        chk(cnt_en == 1'b0, "R4 long stress holds", cnt_en, 0);
        meas_req = 1'b1;
        tick();
        chk(cnt_en == 1'b1, "R5 request opens window", cnt_en, 1);
        tick();
        chk(cnt_en == 1'b1, "R5 window cycle 2", cnt_en, 1);
        tick();
        meas_req = 1'b0;
        chk(cnt_en == 1'b1, "R5 window cycle 3", cnt_en, 1);
        tick();
        chk(cnt_en == 1'b0, "R5 request did not extend window", cnt_en, 0);
        chk(win_done == 1'b1, "R8 done after requested window", win_done, 1);

        // R7 valid ignored in stress, closes a window early
        cfg_meas_len = 4'd15;
        result_valid = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk(cnt_en == 1'b0, "R7 valid ignored in stress", cnt_en, 0);
        end
        result_valid = 1'b0;
        meas_req = 1'b1;
        tick();
        meas_req = 1'b0;
        chk(cnt_en == 1'b1, "R5 window open for R7", cnt_en, 1);
        tick();
        chk(cnt_en == 1'b1, "R7 window cycle 2", cnt_en, 1);
        result_valid = 1'b1;
        tick();
        result_valid = 1'b0;
        chk(cnt_en == 1'b0, "R7 valid closes window", cnt_en, 0);
        chk(win_done == 1'b1, "R7 done on early close", win_done, 1);

        // R9 mode change inside a window applies on stress entry
        tick();
        chk(lines() == 3'b101, "R9 old mode before window", lines(), 3'b101);
        meas_req = 1'b1;
        tick();
        meas_req = 1'b0;
        cfg_mode = 2'b10;
        begin
            int w = 0;
            while (cnt_en && w < 100) begin
                chk(lines() == 3'b000, "R9 lines held in window", lines(), 0);
                w++;
                tick();
            end
            chk(w == CAP, "R6 capped window", w, CAP);
        end
        chk(lines() == 3'b110, "R9 new mode at stress entry", lines(), 3'b110);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule